// File: doc/BRIEF.md
# Digit-Strobed Configuration Strap Decoder

The block reads three configuration straps that share wiring with the display scan. Each strap pin (function, range and control) is tied through the board to one or more of the eight digit strobe lines. While a digit is being driven, a pin tied to that digit reads low. The block watches the pins during the second half of each digit slot and records which digit slots found each pin asserted. From these records it derives a measurement-function code, a range code and a set of independent control flags.

A decoded setting is trusted only after two consecutive complete scans of all eight digits give the same result. This means a single disturbed scan cannot reconfigure the counter. When the accepted function or range changes, a one-cycle change pulse is raised so that the measurement sequencer can abandon its current measurement. When display-off is in force, the strap pins are ignored. It lasts until the hold input returns low.

Top module: `digit_strap_decoder`

## Requirements
- R1: While reset is asserted, and on the first two clock edges after `rst_n` rises, the outputs read `func_code`=0, `range_code`=0, `ctrl_flags`=0 and `cfg_change`=0.
- R2: A pin is counted as asserted for a digit only when it reads low while `late_phase`=1 during that digit's slot. Lows seen only while `late_phase`=0 have no effect.
- R3: Function code from the digit (1..8, `digit_idx`=digit-1) that finds the function pin low: digit 1 gives 0 (frequency), digit 8 gives 1 (period), digit 2 gives 2 (ratio), digit 5 gives 3 (time interval), digit 4 gives 4 (unit counter), digit 3 gives 5 (oscillator self-test). If several digits find the pin low, the lowest-numbered mapped digit wins.
- R4: Range code from the range pin: digit 1 gives 0, digit 2 gives 1, digit 3 gives 2, digit 4 gives 3.
- R5: Each control digit sets its own flag in `ctrl_flags`, and any combination can be set at once: bit 0 is external oscillator (digit 1), bit 1 is 1 MHz select (digit 2), bit 2 is external decimal point (digit 3), bit 3 is display off (digit 4), bit 4 is display test (digit 8).
- R6: A scan closes on the first cycle in which `digit_idx` differs from 7 after a cycle in which it was 7. The first close after reset, or after display-off ends, only starts scanning. A new decoded value is taken on the clock edge of a close whose scan result equals the previous closed scan's result. Any other scan leaves the outputs unchanged.
- R7: `cfg_change` is high for exactly the one cycle in which a newly accepted function or range code first appears. A change that affects only control flags raises no pulse.
- R8: If no digit maps on the function pin (no low seen, or only digits 6 and 7), the function code is 0. If no low is seen on range digits 1 to 4, the range code is 0.
- R9: `ctrl_flags[3]` equals the accepted digit-4 control bit ANDed with `hold`, registered one cycle after `hold`. While it is 1, all strap pins are ignored and partial scans are discarded. After it falls, R6 starts again from an unarmed state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| digit_idx | input | 3 | Index of the digit currently strobed, 0 for digit 1 up to 7 for digit 8 |
| late_phase | input | 1 | High during the second half of the current digit slot |
| func_pin_n | input | 1 | Function strap pin, active low |
| range_pin_n | input | 1 | Range strap pin, active low |
| ctrl_pin_n | input | 1 | Control strap pin, active low |
| hold | input | 1 | Hold level; qualifies display off |
| func_code | output | 3 | Accepted function code |
| range_code | output | 2 | Accepted range code |
| ctrl_flags | output | 5 | Accepted control flags |
| cfg_change | output | 1 | One-cycle pulse on an accepted function or range change |

## Verification
The assertions rely on the scan advancing through all eight digit indices in order, with each slot several cycles long. Under that assumption two scan closes are always far apart, and a change pulse can never be followed directly by another. The stimulus produces a steady 0..7 sweep with four-cycle slots. Pins change only at scan starts or as a half-slot early pulse, and `hold` moves only between scans, so every close sees a whole scan.

// File: rtl/strap_pkg.sv
package strap_pkg;
  localparam int NUM_DIGITS = 8;
  localparam int DIG_W      = $clog2(NUM_DIGITS);
  localparam int FUNC_W     = 3;
  localparam int RNG_W      = 2;
  localparam int CTL_W      = 5;
  localparam int NUM_PINS   = 3;
  localparam int CTL_OFF_BIT = 3;

  typedef enum logic [FUNC_W-1:0] {
    FN_FREQ   = 3'd0,
    FN_PERIOD = 3'd1,
    FN_RATIO  = 3'd2,
    FN_TINT   = 3'd3,
    FN_UNIT   = 3'd4,
    FN_OSC    = 3'd5
  } func_e;

  function automatic func_e decode_func(input logic [NUM_DIGITS-1:0] m);
    if (m[0])      return FN_FREQ;
    else if (m[1]) return FN_RATIO;
    else if (m[2]) return FN_OSC;
    else if (m[3]) return FN_UNIT;
    else if (m[4]) return FN_TINT;
    else if (m[7]) return FN_PERIOD;
    else           return FN_FREQ;
  endfunction

  function automatic logic [RNG_W-1:0] decode_rng(input logic [NUM_DIGITS-1:0] m);
    if (m[0])      return 2'd0;
    else if (m[1]) return 2'd1;
    else if (m[2]) return 2'd2;
    else if (m[3]) return 2'd3;
    else           return 2'd0;
  endfunction

  function automatic logic [CTL_W-1:0] decode_ctl(input logic [NUM_DIGITS-1:0] m);
    return {m[7], m[3], m[2], m[1], m[0]};
  endfunction
endpackage

// File: rtl/scan_tracker.sv
module scan_tracker
  import strap_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIG_W-1:0] digit_idx,
  input  logic             freeze,
  output logic             scan_close,
  output logic             scan_valid
);
  localparam logic [DIG_W-1:0] LAST_DIG = DIG_W'(NUM_DIGITS - 1);

  logic [DIG_W-1:0] prev_q;
  logic             armed_q, armed_d;

  assign scan_close = (prev_q == LAST_DIG) && (digit_idx != LAST_DIG);
  assign scan_valid = scan_close && armed_q && !freeze;

  always_comb begin
    armed_d = armed_q;
    if (freeze)          armed_d = 1'b0;
    else if (scan_close) armed_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= '0;
      armed_q <= 1'b0;
    end else begin
      prev_q  <= digit_idx;
      armed_q <= armed_d;
    end
  end

  assert_valid_armed_R6: assert property (@(posedge clk) disable iff (!rst_n)
    scan_valid |-> $past(armed_d) && !freeze);
endmodule

// File: rtl/pin_accum.sv
module pin_accum
  import strap_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [DIG_W-1:0]      digit_idx,
  input  logic                  late_phase,
  input  logic                  pin_n,
  input  logic                  freeze,
  input  logic                  scan_close,
  output logic [NUM_DIGITS-1:0] mask
);
  logic [NUM_DIGITS-1:0] acc_q, acc_d, hit;

  always_comb begin
    hit = '0;
    if (late_phase && !pin_n && !freeze) hit[digit_idx] = 1'b1;
  end

  always_comb begin
    if (freeze)          acc_d = '0;
    else if (scan_close) acc_d = hit;
    else                 acc_d = acc_q | hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end

  assign mask = acc_q;

  assert_early_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!late_phase && !scan_close) |=> acc_q == ($past(freeze) ? '0 : $past(acc_q)));
endmodule

// File: rtl/cfg_filter.sv
module cfg_filter
  import strap_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  scan_valid,
  input  logic                  freeze,
  input  logic [NUM_DIGITS-1:0] fn_mask,
  input  logic [NUM_DIGITS-1:0] rng_mask,
  input  logic [NUM_DIGITS-1:0] ctl_mask,
  output logic [FUNC_W-1:0]     func_o,
  output logic [RNG_W-1:0]      rng_o,
  output logic [CTL_W-1:0]      ctl_o,
  output logic                  chg_o
);
  func_e            cand_fn, hist_fn_q, fn_q, fn_d;
  logic [RNG_W-1:0] cand_rng, hist_rng_q, rng_q, rng_d;
  logic [CTL_W-1:0] cand_ctl, hist_ctl_q, ctl_q, ctl_d;
  logic             hist_ok_q, hist_ok_d, chg_q, chg_d, agree;

  assign cand_fn  = decode_func(fn_mask);
  assign cand_rng = decode_rng(rng_mask);
  assign cand_ctl = decode_ctl(ctl_mask);
  assign agree    = hist_ok_q && (cand_fn == hist_fn_q) &&
                    (cand_rng == hist_rng_q) && (cand_ctl == hist_ctl_q);

  always_comb begin
    fn_d      = fn_q;
    rng_d     = rng_q;
    ctl_d     = ctl_q;
    chg_d     = 1'b0;
    hist_ok_d = hist_ok_q;
    if (freeze) begin
      hist_ok_d = 1'b0;
    end else if (scan_valid) begin
      hist_ok_d = 1'b1;
      if (agree) begin
        fn_d  = cand_fn;
        rng_d = cand_rng;
        ctl_d = cand_ctl;
        chg_d = (cand_fn != fn_q) || (cand_rng != rng_q);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fn_q       <= FN_FREQ;
      rng_q      <= '0;
      ctl_q      <= '0;
      chg_q      <= 1'b0;
      hist_ok_q  <= 1'b0;
      hist_fn_q  <= FN_FREQ;
      hist_rng_q <= '0;
      hist_ctl_q <= '0;
    end else begin
      fn_q      <= fn_d;
      rng_q     <= rng_d;
      ctl_q     <= ctl_d;
      chg_q     <= chg_d;
      hist_ok_q <= hist_ok_d;
      if (scan_valid) begin
        hist_fn_q  <= cand_fn;
        hist_rng_q <= cand_rng;
        hist_ctl_q <= cand_ctl;
      end
    end
  end

  assign func_o = fn_q;
  assign rng_o  = rng_q;
  assign ctl_o  = ctl_q;
  assign chg_o  = chg_q;

  assert_single_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    chg_q |=> !chg_q);
  assert_hold_between_scans_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !scan_valid |=> $stable(fn_q) && $stable(rng_q) && $stable(ctl_q));
  assert_legal_func_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fn_q inside {FN_FREQ, FN_PERIOD, FN_RATIO, FN_TINT, FN_UNIT, FN_OSC});
endmodule

// File: rtl/digit_strap_decoder.sv
module digit_strap_decoder
  import strap_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        digit_idx,
  input  logic              late_phase,
  input  logic              func_pin_n,
  input  logic              range_pin_n,
  input  logic              ctrl_pin_n,
  input  logic              hold,
  output logic [2:0]        func_code,
  output logic [1:0]        range_code,
  output logic [4:0]        ctrl_flags,
  output logic              cfg_change
);
  logic                  rst_s1_q, rst_int_n;
  logic                  scan_close, scan_valid;
  logic                  doff_q, doff_d;
  logic [NUM_PINS-1:0]   pins_n;
  logic [NUM_DIGITS-1:0] masks [NUM_PINS];
  logic [CTL_W-1:0]      ctl_raw;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q  <= 1'b0;
      rst_int_n <= 1'b0;
    end else begin
      rst_s1_q  <= 1'b1;
      rst_int_n <= rst_s1_q;
    end
  end

  assign pins_n = {ctrl_pin_n, range_pin_n, func_pin_n};

  scan_tracker u_track (
    .clk(clk), .rst_n(rst_int_n), .digit_idx(digit_idx), .freeze(doff_q),
    .scan_close(scan_close), .scan_valid(scan_valid)
  );

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    pin_accum u_acc (
      .clk(clk), .rst_n(rst_int_n), .digit_idx(digit_idx),
      .late_phase(late_phase), .pin_n(pins_n[g]), .freeze(doff_q),
      .scan_close(scan_close), .mask(masks[g])
    );
  end

  cfg_filter u_filt (
    .clk(clk), .rst_n(rst_int_n), .scan_valid(scan_valid), .freeze(doff_q),
    .fn_mask(masks[0]), .rng_mask(masks[1]), .ctl_mask(masks[2]),
    .func_o(func_code), .rng_o(range_code), .ctl_o(ctl_raw), .chg_o(cfg_change)
  );

  assign doff_d = ctl_raw[CTL_OFF_BIT] && hold;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) doff_q <= 1'b0;
    else            doff_q <= doff_d;
  end

  assign ctrl_flags = {ctl_raw[4], doff_q, ctl_raw[2:0]};

  assert_off_needs_hold_R9: assert property (@(posedge clk) disable iff (!rst_int_n)
    ctrl_flags[CTL_OFF_BIT] |-> $past(hold));
  assert_off_freezes_R9: assert property (@(posedge clk) disable iff (!rst_int_n)
    doff_q |=> $stable(func_code) && $stable(range_code));
  assert_pulse_with_update_R7: assert property (@(posedge clk) disable iff (!rst_int_n)
    cfg_change |-> (!$stable(func_code) || !$stable(range_code)));
endmodule

// File: tb/digit_strap_decoder_bench.sv
module digit_strap_decoder_bench;
  localparam int SLOT = 4;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] dig = 3'd0;
  logic       late = 1'b0;
  logic       hold = 1'b0;
  logic [7:0] fn_tie = 8'h00, fn_early = 8'h00, rg_tie = 8'h00, ct_tie = 8'h00;
  logic       fn_n, rg_n, ct_n;
  logic [2:0] func_code;
  logic [1:0] range_code;
  logic [4:0] ctrl_flags;
  logic       cfg_change;

  int tests = 0, fails = 0, pulses = 0, cyc = 0;

  always #5 clk = ~clk;

  assign fn_n = ~(fn_tie[dig] | (fn_early[dig] & ~late));
  assign rg_n = ~rg_tie[dig];
  assign ct_n = ~ct_tie[dig];

  digit_strap_decoder u_digit_strap_decoder (
    .clk(clk), .rst_n(rst_n), .digit_idx(dig), .late_phase(late),
    .func_pin_n(fn_n), .range_pin_n(rg_n), .ctrl_pin_n(ct_n), .hold(hold),
    .func_code(func_code), .range_code(range_code), .ctrl_flags(ctrl_flags),
    .cfg_change(cfg_change)
  );

  // behavioural reference
  int  m_prev, m_fn, m_rg, h_fn, h_rg;
  bit  m_arm, m_hv, m_doff, m_chg;
  bit [4:0] m_ctl, h_ctl;
  bit [7:0] m_acc [3];
  bit [1:0] m_rs;
  int  fn_by_digit [8] = '{0, 2, 5, 4, 3, -1, -1, 1};

  function automatic int ref_fn(bit [7:0] m);
    for (int i = 0; i < 8; i++) if (m[i] && fn_by_digit[i] >= 0) return fn_by_digit[i];
    return 0;
  endfunction
  function automatic int ref_rg(bit [7:0] m);
    for (int i = 0; i < 4; i++) if (m[i]) return i;
    return 0;
  endfunction

  task automatic ref_clear();
    m_prev = 0; m_fn = 0; m_rg = 0; h_fn = 0; h_rg = 0;
    m_arm = 0; m_hv = 0; m_doff = 0; m_chg = 0; m_ctl = 0; h_ctl = 0;
    for (int p = 0; p < 3; p++) m_acc[p] = 0;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_clear();
      m_rs = 0;
    end else begin
      if (!m_rs[1]) ref_clear();
      else begin
        bit nd;
        int cf, cr;
        bit [4:0] cc;
        nd = m_ctl[3] & hold;
        m_chg = 0;
        if (m_doff) begin
          m_arm = 0; m_hv = 0;
          for (int p = 0; p < 3; p++) m_acc[p] = 0;
        end else begin
          if (m_prev == 7 && dig != 3'd7) begin
            if (m_arm) begin
              cf = ref_fn(m_acc[0]);
              cr = ref_rg(m_acc[1]);
              cc = {m_acc[2][7], m_acc[2][3], m_acc[2][2], m_acc[2][1], m_acc[2][0]};
              if (m_hv && cf == h_fn && cr == h_rg && cc == h_ctl) begin
                m_chg = (cf != m_fn) || (cr != m_rg);
                m_fn = cf; m_rg = cr; m_ctl = cc;
              end
              h_fn = cf; h_rg = cr; h_ctl = cc; m_hv = 1;
            end
            m_arm = 1;
            for (int p = 0; p < 3; p++) m_acc[p] = 0;
          end
          if (late) begin
            if (!fn_n) m_acc[0][dig] = 1;
            if (!rg_n) m_acc[1][dig] = 1;
            if (!ct_n) m_acc[2][dig] = 1;
          end
        end
        m_prev = int'(dig);
        m_doff = nd;
      end
      m_rs = {m_rs[0], 1'b1};
    end
  end

  // per-cycle comparison against the reference (R3 R4 R5 R6 R7 R9)
  always @(negedge clk) begin
    logic [4:0] ef;
    ef = {m_ctl[4], m_doff, m_ctl[2:0]};
    tests++;
    if (cfg_change) pulses++;
    if (func_code !== 3'(m_fn) || range_code !== 2'(m_rg) ||
        ctrl_flags !== ef || cfg_change !== m_chg) begin
      fails++;
      $display("FAIL model R6 cyc %0d: got fn=%0d rg=%0d fl=%b ch=%b exp fn=%0d rg=%0d fl=%b ch=%b",
               cyc, func_code, range_code, ctrl_flags, cfg_change, m_fn, m_rg, ef, m_chg);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++;
      $display("FAIL watchdog R6: got %0d cycles exp under 100000", cyc);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic chk(string req, int got, int exp);
    tests++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0d exp %0d", req, got, exp);
    end
  endtask

  task automatic run_scans(int n);
    for (int s = 0; s < n; s++)
      for (int d = 0; d < 8; d++)
        for (int c = 0; c < SLOT; c++) begin
          @(negedge clk);
          dig  = 3'(d);
          late = (c >= SLOT / 2);
        end
  endtask

  initial begin
    int p0;
    int dsel [5] = '{7, 4, 3, 2, 0};
    int fexp [5] = '{1, 3, 4, 5, 0};
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 reset func", func_code, 0);
    chk("R1 reset flags", ctrl_flags, 0);
    chk("R1 reset change", cfg_change, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 early release", func_code, 0);

    fn_tie = 8'h40;
    run_scans(4);
    chk("R8 unmapped digit func", func_code, 0);
    chk("R8 empty range", range_code, 0);

    p0 = pulses;
    fn_tie = 8'h02; rg_tie = 8'h04;
    run_scans(3);
    chk("R3 ratio", func_code, 2);
    chk("R4 range digit3", range_code, 2);
    chk("R7 one pulse", pulses - p0, 1);

    for (int i = 0; i < 5; i++) begin
      fn_tie = 8'(1 << dsel[i]);
      run_scans(3);
      chk("R3 function map", func_code, fexp[i]);
    end
    rg_tie = 8'h01; run_scans(3); chk("R4 range digit1", range_code, 0);
    rg_tie = 8'h02; run_scans(3); chk("R4 range digit2", range_code, 1);
    rg_tie = 8'h08; run_scans(3); chk("R4 range digit4", range_code, 3);
    rg_tie = 8'h00; run_scans(3); chk("R8 no range digit", range_code, 0);

    p0 = pulses;
    ct_tie = 8'h87;
    run_scans(3);
    chk("R5 multi flags", ctrl_flags, 5'b10111);
    chk("R7 no pulse on flags", pulses - p0, 0);

    fn_tie = 8'h02; run_scans(3);
    p0 = pulses;
    fn_tie = 8'h10; run_scans(1);
    fn_tie = 8'h02; run_scans(3);
    chk("R6 glitch scan rejected", func_code, 2);
    chk("R6 no pulse from glitch", pulses - p0, 0);

    fn_early = 8'h80; run_scans(3);
    chk("R2 early half ignored", func_code, 2);
    fn_early = 8'h00;

    ct_tie = 8'h08; run_scans(3);
    chk("R9 off needs hold", ctrl_flags, 0);
    hold = 1'b1;
    run_scans(1);
    chk("R9 off active", ctrl_flags, 5'b01000);
    fn_tie = 8'h80; ct_tie = 8'h00;
    run_scans(3);
    chk("R9 pins ignored func", func_code, 2);
    chk("R9 pins ignored flags", ctrl_flags, 5'b01000);
    hold = 1'b0;
    run_scans(4);
    chk("R9 resume func", func_code, 1);
    chk("R9 resume flags", ctrl_flags, 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule